// File: doc/BRIEF.md
# Processor-Fed I/Q Sample FIFO

This block buffers in-phase (I) and quadrature (Q) baseband samples on their way from a processor bus to a consumer that runs on a reference clock. The processor writes 16-bit words with a write strobe that is not tied to the reference clock. One bus address loads the I holding register and another loads the Q holding register. The strobe is re-timed through a chain of reference-clock flip-flops. From that chain the block makes a one-cycle shift enable, which pushes the held pair into two seven-deep shift chains, one for each channel.

The consumer pulses a read-advance input to step to the next sample. Each channel output comes from a depth-select multiplexer. The multiplexer points at the oldest stored entry, and it selects a constant zero when nothing is stored. A ready flag compares the fill level against a programmable 3-bit threshold and asks the processor for more data. In FM mode only the I path is used: an I write commits a sample, and the Q output is held at zero.

Top module: `iq_sample_fifo`

## Requirements
- R1: A synchronous reset, with `rst` high at a rising `clk` edge, empties both channels, clears `overflow`, and drives `out_i` and `out_q` to zero.
- R2: A rising edge of `bus_wr` with `bus_addr` = 3'b000 loads the I holding register from `bus_data`. With `bus_addr` = 3'b001 it loads the Q holding register. Any other address leaves both holding registers unchanged.
- R3: Each strobe gives exactly one shift. The committed pair first appears at the outputs after the fourth rising `clk` edge that follows the strobe going high. It is not visible after the third.
- R4: With `fm_en` = 0, only a write to address 3'b001 commits the held I/Q pair into the FIFO. With `fm_en` = 1, only a write to address 3'b000 commits.
- R5: Samples leave in write order. `out_i`/`out_q` show the oldest stored pair, and a cycle with `rd_adv` high removes it.
- R6: When the FIFO is empty, `out_i` and `out_q` are zero, and a `rd_adv` pulse has no effect on the fill level.
- R7: Each channel stores at most seven entries. A commit into a full FIFO without a read in the same cycle is dropped, and `overflow` is set and stays set until reset.
- R8: A commit and a read in the same cycle, on a non-empty FIFO, leave the fill level unchanged. The old front entry is removed and the new entry is appended.
- R9: `fifo_ready` is high exactly when the fill level (0 to 7) is less than or equal to `rd_thresh`.
- R10: With `fm_en` = 1, `out_q` is zero and `out_i` shows the oldest I sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all FIFO storage |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Processor write strobe; its rising edge captures data |
| bus_addr | input | 3 | Processor register address (000 = I, 001 = Q) |
| bus_data | input | 16 | Processor write data |
| fm_en | input | 1 | FM mode: I-only path, I write commits |
| rd_adv | input | 1 | Consumer read-advance pulse |
| rd_thresh | input | 3 | Fill-level threshold for the ready flag |
| out_i | output | 16 | Oldest I sample, or zero when empty |
| out_q | output | 16 | Oldest Q sample, or zero when empty or in FM mode |
| fifo_ready | output | 1 | High when more data is wanted |
| overflow | output | 1 | Sticky flag: a commit was dropped on a full FIFO |

## Verification
Some properties are checked on every cycle. These are the one-cycle width of the re-timed shift enable, zero outputs whenever the level is zero, a level that does not move on a read of an empty FIFO or on a simultaneous read and write, the stickiness of the overflow flag, and a forced-zero Q output in FM mode. Other behaviour can only be shown by the bench scenarios. These are the exact four-edge latency from strobe to visible data, address decoding into the holding registers, write order through the chain, dropping at full, and the ready flag across every threshold value. The bench shows these by comparing the outputs with a reference queue.

// File: rtl/iqf_pkg.sv
package iqf_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int FIFO_DEPTH  = 7;
    localparam int ADDR_W      = 3;
    localparam int THRESH_W    = 3;
    localparam int SYNC_STAGES = 4;

    localparam logic [ADDR_W-1:0] SLOT_I = 3'b000;
    localparam logic [ADDR_W-1:0] SLOT_Q = 3'b001;

    typedef enum logic {
        MODE_QASK = 1'b0,
        MODE_FM   = 1'b1
    } path_mode_e;

    typedef enum logic [1:0] {
        LVL_HOLD = 2'b00,
        LVL_POP  = 2'b01,
        LVL_PUSH = 2'b10,
        LVL_SWAP = 2'b11
    } level_op_e;

    // Address that completes a sample in the given mode.
    function automatic logic [ADDR_W-1:0] commit_slot(input path_mode_e mode);
        return (mode == MODE_FM) ? SLOT_I : SLOT_Q;
    endfunction

    function automatic level_op_e level_op(input logic push, input logic pop);
        return level_op_e'({push, pop});
    endfunction

endpackage

// File: rtl/iqf_bus_capture.sv
module iqf_bus_capture #(
    parameter int DW = 16,
    parameter int AW = 3,
    parameter logic [AW-1:0] I_ADDR = '0,
    parameter logic [AW-1:0] Q_ADDR = 1
) (
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic [DW-1:0] hold_i,
    output logic [DW-1:0] hold_q,
    output logic [AW-1:0] last_addr
);

    // Bus-side registers: clocked by the write strobe itself.
    always_ff @(posedge bus_wr) begin
        last_addr <= bus_addr;
        if (bus_addr == I_ADDR) begin
            hold_i <= bus_data;
        end
        if (bus_addr == Q_ADDR) begin
            hold_q <= bus_data;
        end
    end

endmodule

// File: rtl/iqf_strobe_sync.sv
module iqf_strobe_sync #(
    parameter int STAGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic shift_pulse
);

    logic [STAGES-1:0] sync_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= strobe_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // One-cycle pulse on the rise seen between the last two stages.
    assign shift_pulse = sync_q[STAGES-2] & ~sync_q[STAGES-1];

endmodule

// File: rtl/iqf_level_ctrl.sv
module iqf_level_ctrl #(
    parameter int DEPTH = 7,
    parameter int LW    = 3,
    parameter int TW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [TW-1:0] thresh,
    output logic [LW-1:0] level,
    output logic          push_ok,
    output logic          fifo_ready,
    output logic          overflow
);
    import iqf_pkg::*;

    logic full, empty, pop_ok;
    level_op_e op;

    assign full    = (int'(level) == DEPTH);
    assign empty   = (level == '0);
    assign pop_ok  = pop_req & ~empty;
    assign push_ok = push_req & (~full | pop_ok);
    assign op      = level_op(push_ok, pop_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else begin
            case (op)
                LVL_PUSH: level <= level + 1'b1;
                LVL_POP:  level <= level - 1'b1;
                default:  level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       overflow <= 1'b0;
        else if (push_req && !push_ok) overflow <= 1'b1;
    end

    assign fifo_ready = (int'(level) <= int'(thresh));

endmodule

// File: rtl/iqf_tap_chain.sv
module iqf_tap_chain #(
    parameter int DW    = 16,
    parameter int DEPTH = 7,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic [DW-1:0] din,
    input  logic [LW-1:0] sel,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] taps [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_tap
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)           taps[g] <= '0;
                    else if (shift_en) taps[g] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst)           taps[g] <= '0;
                    else if (shift_en) taps[g] <= taps[g-1];
                end
            end
        end
    endgenerate

    // Select 0 picks the zero input; select n picks tap n-1 (oldest entry).
    always_comb begin
        dout = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(sel) == k + 1) dout = taps[k];
        end
    end

endmodule

// File: rtl/iq_sample_fifo.sv
module iq_sample_fifo #(
    parameter int DATA_W      = iqf_pkg::SAMPLE_W,
    parameter int DEPTH       = iqf_pkg::FIFO_DEPTH,
    parameter int ADDR_W      = iqf_pkg::ADDR_W,
    parameter int THR_W       = iqf_pkg::THRESH_W,
    parameter int SYNC_STAGES = iqf_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              fm_en,
    input  logic              rd_adv,
    input  logic [THR_W-1:0]  rd_thresh,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q,
    output logic              fifo_ready,
    output logic              overflow
);
    import iqf_pkg::*;

    localparam int LEVEL_W = $clog2(DEPTH + 1);
    localparam int N_CHAN  = 2;

    logic [DATA_W-1:0]  hold_i, hold_q;
    logic [ADDR_W-1:0]  last_addr;
    logic               sync_pulse;
    logic               push_req;
    logic               push_ok;
    logic [LEVEL_W-1:0] occ_level;
    path_mode_e         mode;
    logic [DATA_W-1:0]  chan_in  [N_CHAN];
    logic [DATA_W-1:0]  chan_out [N_CHAN];

    iqf_bus_capture #(
        .DW(DATA_W), .AW(ADDR_W),
        .I_ADDR(ADDR_W'(SLOT_I)), .Q_ADDR(ADDR_W'(SLOT_Q))
    ) u_capture (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .hold_i    (hold_i),
        .hold_q    (hold_q),
        .last_addr (last_addr)
    );

    iqf_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .strobe_async (bus_wr),
        .shift_pulse  (sync_pulse)
    );

    assign mode     = fm_en ? MODE_FM : MODE_QASK;
    assign push_req = sync_pulse && (last_addr == ADDR_W'(commit_slot(mode)));

    iqf_level_ctrl #(.DEPTH(DEPTH), .LW(LEVEL_W), .TW(THR_W)) u_level (
        .clk        (clk),
        .rst        (rst),
        .push_req   (push_req),
        .pop_req    (rd_adv),
        .thresh     (rd_thresh),
        .level      (occ_level),
        .push_ok    (push_ok),
        .fifo_ready (fifo_ready),
        .overflow   (overflow)
    );

    assign chan_in[0] = hold_i;
    assign chan_in[1] = hold_q;

    genvar c;
    generate
        for (c = 0; c < N_CHAN; c++) begin : g_chan
            iqf_tap_chain #(.DW(DATA_W), .DEPTH(DEPTH), .LW(LEVEL_W)) u_chain (
                .clk      (clk),
                .rst      (rst),
                .shift_en (push_ok),
                .din      (chan_in[c]),
                .sel      (occ_level),
                .dout     (chan_out[c])
            );
        end
    endgenerate

    // Two-way path select: FM mode carries only the I channel.
    assign out_i = chan_out[0];
    assign out_q = (mode == MODE_FM) ? '0 : chan_out[1];

endmodule

// File: rtl/iq_sample_fifo_chk.sv
module iq_sample_fifo_chk #(
    parameter int DW    = 16,
    parameter int DEPTH = 7,
    parameter int LW    = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          fm_en,
    input logic          rd_adv,
    input logic          pulse,
    input logic          push_req,
    input logic          push_ok,
    input logic [LW-1:0] level,
    input logic          overflow,
    input logic          fifo_ready,
    input logic [DW-1:0] out_i,
    input logic [DW-1:0] out_q
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (level == '0) && !overflow);

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    p_empty_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> (out_i == '0) && (out_q == '0));

    p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
        ((level == '0) && rd_adv && !push_ok) |=> (level == '0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        ((int'(level) == DEPTH) && push_req && !rd_adv) |=> ((int'(level) == DEPTH) && overflow));

    p_sticky_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_swap_level_r8: assert property (@(posedge clk) disable iff (rst)
        (push_ok && rd_adv && (level != '0)) |=> $stable(level));

    p_ready_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> fifo_ready);

    p_fm_q_zero_r10: assert property (@(posedge clk) disable iff (rst)
        fm_en |-> (out_q == '0));

endmodule

bind iq_sample_fifo iq_sample_fifo_chk #(.DW(DATA_W), .DEPTH(DEPTH), .LW(LEVEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fm_en      (fm_en),
    .rd_adv     (rd_adv),
    .pulse      (sync_pulse),
    .push_req   (push_req),
    .push_ok    (push_ok),
    .level      (occ_level),
    .overflow   (overflow),
    .fifo_ready (fifo_ready),
    .out_i      (out_i),
    .out_q      (out_q)
);

// File: tb/iq_sample_fifo_tb.sv
`timescale 1ns/1ps
module iq_sample_fifo_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        fm_en = 1'b0;
    logic        rd_adv = 1'b0;
    logic [2:0]  rd_thresh = 3'd2;
    logic [15:0] out_i, out_q;
    logic        fifo_ready, overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] sb [$];
    logic        exp_ovf = 1'b0;

    always #2.5 clk = ~clk;

    iq_sample_fifo u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_data(bus_data), .fm_en(fm_en), .rd_adv(rd_adv),
        .rd_thresh(rd_thresh), .out_i(out_i), .out_q(out_q),
        .fifo_ready(fifo_ready), .overflow(overflow)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: one processor write; leaves time for the re-timed shift.
    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_data = d;
        #1 bus_wr = 1'b1;
        repeat (2) @(negedge clk);
        bus_wr = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic model_push(input logic [15:0] i, input logic [15:0] q);
        if (sb.size() < 7) sb.push_back({i, q});
        else               exp_ovf = 1'b1;
    endtask

    task automatic commit_pair(input logic [15:0] i, input logic [15:0] q);
        bus_write(3'b000, i);
        bus_write(3'b001, q);
        model_push(i, q);
    endtask

    // Monitor: compare the outputs with the scoreboard front.
    task automatic check_front(input string req);
        logic [31:0] exp;
        #1;
        exp = (sb.size() != 0) ? sb[0] : 32'h0;
        chk(req, "out_i", {16'h0, out_i}, {16'h0, exp[31:16]});
        chk(req, "out_q", {16'h0, out_q}, {16'h0, exp[15:0]});
    endtask

    task automatic check_level(input string req);
        logic [2:0] keep;
        keep = rd_thresh;
        for (int t = 0; t < 8; t++) begin
            rd_thresh = 3'(t);
            #0.2;
            chk(req, $sformatf("fifo_ready thr=%0d", t),
                {31'h0, fifo_ready}, {31'h0, (sb.size() <= t)});
        end
        rd_thresh = keep;
    endtask

    task automatic read_one(input string req);
        @(negedge clk);
        check_front(req);
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
        if (sb.size() != 0) void'(sb.pop_front());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_front("R1");
        chk("R1", "overflow", {31'h0, overflow}, 32'h0);
        check_level("R1");

        // R4: an I write alone does not commit in QASK mode
        bus_write(3'b000, 16'hA001);
        check_front("R4");
        check_level("R4");

        // R2 / R5: the Q write commits the held pair
        bus_write(3'b001, 16'hB001);
        model_push(16'hA001, 16'hB001);
        check_front("R2");
        check_level("R3");

        // R2: a write to another address touches no holding register
        bus_write(3'b010, 16'hDEAD);
        bus_write(3'b001, 16'hB002);
        model_push(16'hA001, 16'hB002);
        check_level("R2");
        read_one("R5");
        check_front("R2");
        read_one("R2");
        check_front("R6");

        // R3: exact latency, visible after the fourth edge only
        bus_write(3'b000, 16'h1111);
        @(negedge clk);
        bus_addr = 3'b001;
        bus_data = 16'h2222;
        #1 bus_wr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        #1;
        chk("R3", "out_i before 4th edge", {16'h0, out_i}, 32'h0);
        @(negedge clk);
        #1;
        chk("R3", "out_i after 4th edge", {16'h0, out_i}, 32'h1111);
        chk("R3", "out_q after 4th edge", {16'h0, out_q}, 32'h2222);
        repeat (5) @(negedge clk);
        model_push(16'h1111, 16'h2222);
        check_level("R3");

        // R7: fill to seven, then one more is dropped
        for (int k = 0; k < 7; k++) begin
            commit_pair(16'h3000 + 16'(k), 16'h4000 + 16'(k));
        end
        check_level("R7");
        chk("R7", "overflow", {31'h0, overflow}, {31'h0, exp_ovf});

        // R5: drain in write order
        for (int k = 0; k < 7; k++) begin
            read_one("R5");
        end
        check_level("R5");

        // R6: read on empty, zero output, level unchanged
        read_one("R6");
        check_front("R6");
        check_level("R6");
        chk("R7", "overflow sticky", {31'h0, overflow}, 32'h1);

        // R8: read and commit in the same cycle
        commit_pair(16'h5001, 16'h6001);
        commit_pair(16'h5002, 16'h6002);
        bus_write(3'b000, 16'h5003);
        @(negedge clk);
        bus_addr = 3'b001;
        bus_data = 16'h6003;
        #1 bus_wr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        check_front("R8");
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
        void'(sb.pop_front());
        model_push(16'h5003, 16'h6003);
        repeat (4) @(negedge clk);
        check_level("R8");
        read_one("R8");
        read_one("R8");
        check_front("R8");

        // R10 / R4: FM mode, an I write commits and Q reads zero
        fm_en = 1'b1;
        bus_write(3'b000, 16'h7777);
        model_push(16'h7777, 16'h0000);
        check_front("R10");
        check_level("R4");
        bus_write(3'b001, 16'h8888);
        check_level("R4");
        read_one("R10");
        check_front("R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule